// File: doc/BRIEF.md
# Packet Burst Striping Transmitter

This block accepts packets as a stream of 64-bit words, each tagged with start and end markers and a channel number. It breaks every packet into bursts of bounded length and writes a control word in front of each burst. Control words report packet start, packet end or idle. They also copy a 16-bit Xon/Xoff flow-control field from an input, and they carry a 24-bit CRC over the data words of the burst just finished.

Exactly one word leaves the block per clock cycle. It is written into the output register of one lane, and a per-lane valid strobe and a data/control flag go with it. The lane is picked by a round-robin pointer that steps only through the lanes that are enabled, so a failed lane can be masked out and its traffic moved onto the others. When no packet data is available the block fills the cycle with an idle control word, so the word stream never stops.

Top module: `burst_stripe_tx`

## Requirements
- R1: While rst_ni is low and after it is released, all lane valid strobes, all lane control flags and in_ready_o are low until the first clock edge.
- R2: When no burst is open and a word with in_sop_i is offered, the block emits a control word with start (bit 63) and burst-start (bit 61) set and the channel in bits 55:48, does not accept the word that cycle, then accepts and emits the packet's data words one per cycle.
- R3: A burst never holds more than MAX_BURST data words. After MAX_BURST words of a packet that has not ended, a control word with burst-start set, start and end clear, and the current channel follows.
- R4: The word after a burst's last data word that carried in_eop_i is a control word with end (bit 62) set. If a start word is offered in that cycle, the same control word also has start and burst-start set and carries the new channel; otherwise those bits and the channel are zero.
- R5: Bits 23:0 of each burst-closing control word hold a CRC-24 with polynomial CRC_POLY (default 0x328B63). It is seeded with all ones, fed the burst's data words most significant bit first, and has no final inversion. On control words that open a new packet or are idle, these bits are zero.
- R6: If no burst is open and no start word is offered, an idle control word is emitted: only the flow-control field is set. If a burst is open and the source has a gap, an idle control word is emitted, the burst stays open and its CRC is unaffected.
- R7: Bits 47:32 of every control word equal fc_i in the cycle the word is formed. All other bits not named above are zero.
- R8: lane_ctrl_o of the lane that receives a word is high for control words and low for data words.
- R9: Each cycle after the first edge out of reset, exactly one lane valid strobe is high. Successive words go to the next enabled lane in ascending index order, wrapping from the highest index to the lowest.
- R10: After reset the active lane mask is all ones and the pointer is lane 0. lane_mask_i is loaded only in cycles that emit a control word while no burst is open or that close a burst, and it governs lane selection from the following word on.
- R11: in_ready_o is high exactly when a burst is open, it holds fewer than MAX_BURST data words and no end marker is pending. It does not depend on in_valid_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input word offered |
| in_ready_o | output | 1 | Input word accepted this cycle when valid |
| in_data_i | input | 64 | Packet data word |
| in_sop_i | input | 1 | First word of packet |
| in_eop_i | input | 1 | Last word of packet |
| in_chan_i | input | CHAN_W | Channel number of packet |
| fc_i | input | 16 | Xon/Xoff bits copied into control words |
| lane_mask_i | input | NUM_LANES | Enabled lanes, one bit per lane |
| lane_valid_o | output | NUM_LANES | Per-lane word strobe |
| lane_ctrl_o | output | NUM_LANES | Per-lane control flag of held word |
| lane_data_o | output | NUM_LANES*64 | Per-lane held word, lane k at bits 64k+63:64k |

## Verification
The reference model is run on single-word packets, packets of exactly one burst, and packets one word past a burst. These separate a correct burst limit from off-by-one splitting. Long packets sent back to back exercise the combined end-and-start control word. A source with periodic gaps checks that idle fill neither closes a burst nor disturbs its CRC. Lane mask changes made in the middle of a burst, including a single-lane mask, show whether the reload waits for a boundary and whether the pointer skips disabled lanes and wraps.

// File: rtl/burst_stripe_pkg.sv
package burst_stripe_pkg;
  localparam int WORD_W  = 64;
  localparam int CRC_W   = 24;
  localparam int FC_W    = 16;
  localparam int CHF_W   = 8;
  localparam int SOP_POS = 63;
  localparam int EOP_POS = 62;
  localparam int BST_POS = 61;
  localparam int CHF_LSB = 48;
  localparam int FC_LSB  = 32;
  localparam logic [CRC_W-1:0] CRC_SEED = '1;

  function automatic logic [WORD_W-1:0] pack_ctrl(
    input logic sop, input logic eop, input logic bst,
    input logic [CHF_W-1:0] chan, input logic [FC_W-1:0] fc,
    input logic [CRC_W-1:0] crc);
    logic [WORD_W-1:0] w;
    w = '0;
    w[SOP_POS] = sop;
    w[EOP_POS] = eop;
    w[BST_POS] = bst;
    w[CHF_LSB +: CHF_W] = chan;
    w[FC_LSB +: FC_W] = fc;
    w[CRC_W-1:0] = crc;
    return w;
  endfunction
endpackage

// File: rtl/stripe_crc24.sv
module stripe_crc24 #(
  parameter int          DATA_W = 64,
  parameter logic [23:0] POLY   = 24'h328B63
) (
  input  logic [23:0]       crc_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [23:0]       crc_o
);
  always_comb begin
    logic [23:0] c;
    logic        fb;
    c = crc_i;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      fb = c[23] ^ data_i[i];
      c  = {c[22:0], 1'b0};
      if (fb) c = c ^ POLY;
    end
    crc_o = c;
  end
endmodule

// File: rtl/stripe_lane_rr.sv
module stripe_lane_rr #(
  parameter int LANES = 4,
  localparam int LW   = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [LW-1:0]    cur_i,
  input  logic [LANES-1:0] mask_i,
  output logic [LW-1:0]    next_o
);
  logic found;
  always_comb begin
    next_o = cur_i;
    found  = 1'b0;
    for (int k = 1; k <= LANES; k++) begin
      int j;
      j = (int'(cur_i) + k) % LANES;
      if (!found && mask_i[j]) begin
        next_o = LW'(j);
        found  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/burst_stripe_tx.sv
module burst_stripe_tx
  import burst_stripe_pkg::*;
#(
  parameter int          NUM_LANES = 4,
  parameter int          MAX_BURST = 8,
  parameter int          CHAN_W    = 8,
  parameter logic [23:0] CRC_POLY  = 24'h328B63
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        in_valid_i,
  output logic                        in_ready_o,
  input  logic [WORD_W-1:0]           in_data_i,
  input  logic                        in_sop_i,
  input  logic                        in_eop_i,
  input  logic [CHAN_W-1:0]           in_chan_i,
  input  logic [FC_W-1:0]             fc_i,
  input  logic [NUM_LANES-1:0]        lane_mask_i,
  output logic [NUM_LANES-1:0]        lane_valid_o,
  output logic [NUM_LANES-1:0]        lane_ctrl_o,
  output logic [NUM_LANES*WORD_W-1:0] lane_data_o
);
  localparam int LANE_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;
  localparam int CNT_W  = $clog2(MAX_BURST + 1);

  logic                 burst_q, eop_pend_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [CRC_W-1:0]     crc_q, crc_nx;
  logic [CHF_W-1:0]     chan_q;
  logic [NUM_LANES-1:0] mask_q, mask_d;
  logic [LANE_W-1:0]    ptr_q, ptr_d;

  logic room, close_b, take, start_b, bnd, ctrl_w;
  logic w_sop, w_eop, w_bst;
  logic [CHF_W-1:0]  w_chan;
  logic [CRC_W-1:0]  w_crc;
  logic [WORD_W-1:0] word;

  always_comb begin
    room    = burst_q && (cnt_q < CNT_W'(MAX_BURST)) && !eop_pend_q;
    close_b = burst_q && !room;
    take    = room && in_valid_i;
    start_b = !burst_q && in_valid_i && in_sop_i;
    w_sop = 1'b0; w_eop = 1'b0; w_bst = 1'b0;
    w_chan = '0; w_crc = '0;
    if (close_b) begin
      w_crc = crc_q;
      if (eop_pend_q) begin
        // end of packet; next packet may start in the same word
        w_eop = 1'b1;
        if (in_valid_i && in_sop_i) begin
          w_sop  = 1'b1;
          w_bst  = 1'b1;
          w_chan = CHF_W'(in_chan_i);
        end
      end else begin
        w_bst  = 1'b1;
        w_chan = chan_q;
      end
    end else if (start_b) begin
      w_sop  = 1'b1;
      w_bst  = 1'b1;
      w_chan = CHF_W'(in_chan_i);
    end
    ctrl_w = !take;
    word   = take ? in_data_i : pack_ctrl(w_sop, w_eop, w_bst, w_chan, fc_i, w_crc);
    bnd    = close_b || !burst_q;
    mask_d = bnd ? lane_mask_i : mask_q;
  end

  assign in_ready_o = room;

  stripe_crc24 #(.DATA_W(WORD_W), .POLY(CRC_POLY)) u_crc (
    .crc_i (crc_q),
    .data_i(in_data_i),
    .crc_o (crc_nx)
  );

  stripe_lane_rr #(.LANES(NUM_LANES)) u_rr (
    .cur_i (ptr_q),
    .mask_i(mask_d),
    .next_o(ptr_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      burst_q    <= 1'b0;
      eop_pend_q <= 1'b0;
      cnt_q      <= '0;
      crc_q      <= CRC_SEED;
      chan_q     <= '0;
      mask_q     <= '1;
      ptr_q      <= '0;
    end else begin
      mask_q <= mask_d;
      ptr_q  <= ptr_d;
      if (take) begin
        cnt_q      <= cnt_q + CNT_W'(1);
        crc_q      <= crc_nx;
        eop_pend_q <= in_eop_i;
      end else if (close_b || start_b) begin
        burst_q    <= w_bst;
        cnt_q      <= '0;
        crc_q      <= CRC_SEED;
        eop_pend_q <= 1'b0;
        chan_q     <= w_chan;
      end
    end
  end

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    logic              v_q, c_q;
    logic [WORD_W-1:0] d_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q <= 1'b0;
        c_q <= 1'b0;
        d_q <= '0;
      end else begin
        v_q <= (ptr_q == LANE_W'(g));
        if (ptr_q == LANE_W'(g)) begin
          c_q <= ctrl_w;
          d_q <= word;
        end
      end
    end
    assign lane_valid_o[g]                 = v_q;
    assign lane_ctrl_o[g]                  = c_q;
    assign lane_data_o[g*WORD_W +: WORD_W] = d_q;
  end
endmodule

// File: rtl/burst_stripe_tx_chk.sv
module burst_stripe_tx_chk
  import burst_stripe_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int MAX_BURST = 8
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        in_valid_i,
  input logic                        in_ready_o,
  input logic [NUM_LANES-1:0]        lane_valid_o,
  input logic [NUM_LANES-1:0]        lane_ctrl_o,
  input logic [NUM_LANES*WORD_W-1:0] lane_data_o
);
  logic              any_v, cur_ctrl, seen_q;
  logic [WORD_W-1:0] cur_word;
  int                run_q;

  always_comb begin
    any_v = 1'b0; cur_ctrl = 1'b0; cur_word = '0;
    for (int k = 0; k < NUM_LANES; k++) begin
      if (lane_valid_o[k]) begin
        any_v    = 1'b1;
        cur_ctrl = lane_ctrl_o[k];
        cur_word = lane_data_o[k*WORD_W +: WORD_W];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      run_q  <= 0;
    end else begin
      seen_q <= 1'b1;
      if (any_v) begin
        if (!cur_ctrl) run_q <= run_q + 1;
        else if (cur_word[BST_POS] || cur_word[EOP_POS]) run_q <= 0;
      end
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (lane_valid_o == '0));

  assert_one_lane_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> ($countones(lane_valid_o) == 1));

  assert_no_double_lane_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lane_valid_o));

  assert_accept_emits_data_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> (any_v && !cur_ctrl));

  assert_burst_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= MAX_BURST);
endmodule

bind burst_stripe_tx burst_stripe_tx_chk #(.NUM_LANES(NUM_LANES), .MAX_BURST(MAX_BURST)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .lane_valid_o(lane_valid_o),
  .lane_ctrl_o (lane_ctrl_o),
  .lane_data_o (lane_data_o)
);

// File: tb/burst_stripe_tx_bench.sv
module burst_stripe_tx_bench;
  localparam int N     = 4;
  localparam int MAXB  = 8;
  localparam logic [23:0] POLY = 24'h328B63;

  logic clk_i = 1'b0;
  logic rst_ni;
  logic in_valid_i, in_ready_o, in_sop_i, in_eop_i;
  logic [63:0] in_data_i;
  logic [7:0]  in_chan_i;
  logic [15:0] fc_i;
  logic [N-1:0] lane_mask_i, lane_valid_o, lane_ctrl_o;
  logic [N*64-1:0] lane_data_o;

  always #2 clk_i = ~clk_i;

  burst_stripe_tx #(.NUM_LANES(N), .MAX_BURST(MAXB)) u_burst_stripe_tx (.*);

  typedef struct { logic [63:0] d; bit s; bit e; logic [7:0] c; } beat_t;
  beat_t q[$];

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit gap_en = 0;
  logic [15:0] fc_next = 16'h0000;
  logic [N-1:0] mask_next = '1;
  bit started = 0;

  // model state
  bit m_burst, m_eop;
  int m_cnt, m_ptr;
  logic [23:0] m_crc;
  logic [7:0] m_chan;
  logic [N-1:0] m_mask;
  // expectation for next sample
  int exp_lane;
  bit exp_ctrl, exp_close;
  logic [63:0] exp_word;
  string exp_tag;

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [23:0] crc_upd(logic [23:0] c, logic [63:0] d);
    for (int i = 63; i >= 0; i--) begin
      bit fb = c[23] ^ d[i];
      c = c << 1;
      if (fb) c = c ^ POLY;
    end
    return c;
  endfunction

  function automatic int next_lane(int p, logic [N-1:0] m);
    for (int k = 1; k <= N; k++) begin
      int j = (p + k) % N;
      if (m[j]) return j;
    end
    return p;
  endfunction

  task automatic drive();
    cyc++;
    fc_i = fc_next;
    lane_mask_i = mask_next;
    if (q.size() > 0 && !(gap_en && (cyc % 3 == 1))) begin
      in_valid_i = 1; in_data_i = q[0].d; in_sop_i = q[0].s; in_eop_i = q[0].e; in_chan_i = q[0].c;
    end else begin
      in_valid_i = 0; in_data_i = '0; in_sop_i = 0; in_eop_i = 0; in_chan_i = '0;
    end
  endtask

  task automatic step();
    bit room, close, bnd, s, e, b;
    logic [7:0] ch;
    logic [23:0] cr;
    room = m_burst && (m_cnt < MAXB) && !m_eop;
    chk(in_ready_o === room, "R11", 64'(in_ready_o), 64'(room));
    close = m_burst && !room;
    bnd = close || !m_burst;
    exp_close = 0;
    if (room && in_valid_i) begin
      exp_word = in_data_i; exp_ctrl = 0; exp_tag = "R2";
      m_crc = crc_upd(m_crc, in_data_i);
      m_cnt++; m_eop = in_eop_i;
      void'(q.pop_front());
    end else begin
      exp_ctrl = 1; s = 0; e = 0; b = 0; ch = '0; cr = '0;
      if (close) begin
        cr = m_crc; exp_close = 1;
        if (m_eop) begin
          e = 1; exp_tag = "R4";
          if (in_valid_i && in_sop_i) begin s = 1; b = 1; ch = in_chan_i; end
        end else begin
          b = 1; ch = m_chan; exp_tag = "R3";
        end
        m_burst = b; m_cnt = 0; m_crc = '1; m_eop = 0; m_chan = ch;
      end else if (!m_burst && in_valid_i && in_sop_i) begin
        s = 1; b = 1; ch = in_chan_i; exp_tag = "R2";
        m_burst = 1; m_cnt = 0; m_crc = '1; m_chan = ch;
      end else begin
        exp_tag = "R6";
      end
      exp_word = '0;
      exp_word[63] = s; exp_word[62] = e; exp_word[61] = b;
      exp_word[55:48] = ch; exp_word[47:32] = fc_i; exp_word[23:0] = cr;
    end
    exp_lane = m_ptr;
    if (bnd) m_mask = lane_mask_i;
    m_ptr = next_lane(m_ptr, m_mask);
  endtask

  task automatic compare();
    logic [63:0] got;
    got = lane_data_o[exp_lane*64 +: 64];
    chk(lane_valid_o == N'(1 << exp_lane), "R9 R10", 64'(lane_valid_o), 64'(1 << exp_lane));
    chk(lane_ctrl_o[exp_lane] == exp_ctrl, "R8", 64'(lane_ctrl_o[exp_lane]), 64'(exp_ctrl));
    chk(got == exp_word, exp_tag, got, exp_word);
    if (exp_ctrl) chk(got[47:32] == exp_word[47:32], "R7", 64'(got[47:32]), 64'(exp_word[47:32]));
    if (exp_close) chk(got[23:0] == exp_word[23:0], "R5", 64'(got[23:0]), 64'(exp_word[23:0]));
  endtask

  task automatic push_pkt(int pid, int len, int chan);
    for (int i = 0; i < len; i++) begin
      beat_t bt;
      bt.d = {8'(pid), 8'(i), 48'h5A5A_1234_0F0F ^ 48'(i * 977 + pid * 31)};
      bt.s = (i == 0); bt.e = (i == len - 1); bt.c = 8'(chan);
      q.push_back(bt);
    end
  endtask

  task automatic drain();
    int guard = 0;
    while (q.size() > 0 && guard < 5000) begin @(posedge clk_i); guard++; end
    repeat (12) @(posedge clk_i);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // driver and reference model
  initial begin
    rst_ni = 0; in_valid_i = 0; in_data_i = '0; in_sop_i = 0; in_eop_i = 0;
    in_chan_i = '0; fc_i = '0; lane_mask_i = '1;
    repeat (3) @(negedge clk_i);
    chk(lane_valid_o == '0, "R1", 64'(lane_valid_o), 64'd0);
    chk(lane_ctrl_o == '0, "R1", 64'(lane_ctrl_o), 64'd0);
    chk(in_ready_o == 1'b0, "R1", 64'(in_ready_o), 64'd0);
    rst_ni = 1;
    m_burst = 0; m_eop = 0; m_cnt = 0; m_ptr = 0; m_crc = '1; m_chan = '0; m_mask = '1;
    started = 1;
    forever begin
      drive();
      #1;
      step();
      @(negedge clk_i);
      compare();
    end
  end

  // scenarios
  initial begin
    wait (started);
    repeat (6) @(posedge clk_i);               // idle fill, R6
    push_pkt(1, 1, 3); drain();                // single word, R2 R4
    fc_next = 16'hA0F5;
    push_pkt(2, MAXB, 5); drain();             // exactly one burst, R3
    push_pkt(3, MAXB + 1, 7); drain();         // one past a burst, R3 R5
    push_pkt(4, 20, 9); push_pkt(5, 3, 11); drain();  // back to back, R4
    gap_en = 1;
    push_pkt(6, 12, 2); push_pkt(7, 5, 4); drain();   // gaps, R6
    gap_en = 0;
    push_pkt(8, 30, 6);
    repeat (5) @(posedge clk_i); mask_next = 4'b1011;  // mid burst, R10
    repeat (11) @(posedge clk_i); mask_next = 4'b0100; fc_next = 16'h00FF;
    repeat (13) @(posedge clk_i); mask_next = 4'b1001;
    drain();
    mask_next = 4'b0110; push_pkt(9, 2, 1); drain();
    mask_next = '1; push_pkt(10, 17, 12); drain();
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    summary();
    $finish;
  end
endmodule